// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that runs block transfers described by in-memory descriptors. Software writes the address of the first descriptor, rings a doorbell and sets the channel's enable bit. The channel then reads the descriptor through its memory master port and copies data from the source address to the target address, one transfer unit at a time. Unit sizes run from 1 byte to 128 bytes, and the source and target addresses each increment only if the command word asks for it.

Descriptors can be chained. When a descriptor finishes with its link bit set, the channel fetches the next one. That descriptor lies at the base address plus sixteen bytes times an 8-bit offset held in the top of the count word. An offset of zero points back to the base, so a chain can loop until software stops it. The channel raises its interrupt only when it finishes a descriptor whose link bit is clear. It also raises it on an address error or when it halts, and it records each of these events in its status register.

The register slave port has one write strobe and reads combinationally. The memory master port is a request/acknowledge port of 32-bit words with byte enables. Each beat completes in the cycle in which `mem_ack` is high.

Top module: `dma_chan`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0, `irq` is low and `mem_req` is low. The live count register (offset 0x0C) also reads 0.
- R2: Rings the doorbell by writing 1 to bit 0 of offset 0x08, after the descriptor base has been written to offset 0x04. Once status bit 0 (enable) is also set, the channel reads five 32-bit words at increasing addresses from the base. Their order is: command, source address, target address, count word, request type. Status bit 30 (eight-word descriptor format) is stored as written.
- R3: Command bits 10:8 select the unit size: 0=4 B, 1=1 B, 2=2 B, 3=16 B, 4=32 B, 5=64 B, 6=128 B. A 1-byte or 2-byte unit moves only its own byte lanes of the target word and leaves the other lanes unchanged. A larger unit moves size/4 whole words.
- R4: Command bit 23 makes the source address advance by the unit size after each unit, and bit 22 does the same for the target address. A side whose bit is clear uses the same word address for every beat.
- R5: Bits 23:0 of the count word give the number of units. The live count at offset 0x0C drops by one after each completed unit and reads 0 when the descriptor is done. A count of 0 moves no data.
- R6: A descriptor with command bit 0 (link) set is followed by a fetch at the base plus 16 × count-word bits 31:24. Reaching a linked descriptor's end neither sets the terminated flag nor raises `irq`.
- R7: At the end of a descriptor with link clear, the channel sets status bit 3 (terminated). `irq` rises only if command bit 1 (interrupt enable) of that descriptor is set.
- R8: A source or target address that is not aligned to the unit size, or a size code of 7, stops the channel. It then sets status bit 4 (address error) and raises `irq`, and it writes no data.
- R9: A request type other than 8 (auto-request) stops the channel. It then sets status bit 2 (halt) and raises `irq`, and it writes no data.
- R10: A count-word offset of 0 on a linked descriptor repeats the chain with no terminated flag. Writing the status register with bit 0 clear stops the channel at once. Any flag bit written as 0 is cleared, and `irq` falls once no flag is left that drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the channel with its defaults: a 24-bit count, an 8-bit chain offset in 16-byte steps, and a five-word fetch. A 4 KiB zero-wait memory model sits behind the master port. With these values, every unit size up to 16 bytes fits in small buffers, and two-descriptor chains are reachable. So are looping chains with a zero offset and counts of a hundred units, which are long enough to read the live count in mid-transfer. The zero-wait memory makes each 4-byte unit take exactly two cycles, so a mid-transfer count can be bracketed tightly.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_FETCH, ENG_CHECK, ENG_READ, ENG_WRITE, ENG_END
  } eng_state_t;

  localparam int CMD_LINK_BIT = 0;
  localparam int CMD_TIE_BIT  = 1;
  localparam int CMD_DINC_BIT = 22;
  localparam int CMD_SINC_BIT = 23;
  localparam int CMD_TSZ_LO   = 8;

  localparam logic [31:0] REQ_AUTO = 32'd8;

  function automatic logic [2:0] cmd_size(input logic [31:0] cmd);
    return cmd[CMD_TSZ_LO +: 3];
  endfunction

  // Bytes carried by one unit; 0 marks an unusable code.
  function automatic logic [7:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd0: return 8'd4;
      3'd1: return 8'd1;
      3'd2: return 8'd2;
      3'd3: return 8'd16;
      3'd4: return 8'd32;
      3'd5: return 8'd64;
      3'd6: return 8'd128;
      default: return 8'd0;
    endcase
  endfunction

  // Word beats in a unit, minus one.
  function automatic logic [4:0] beats_m1(input logic [2:0] code);
    logic [7:0] b;
    b = unit_bytes(code);
    if (b < 8'd4) return 5'd0;
    return 5'(b[7:2] - 6'd1);
  endfunction

  function automatic logic addr_aligned(input logic [31:0] addr, input logic [2:0] code);
    logic [7:0] b;
    b = unit_bytes(code);
    if (b == 8'd0) return 1'b0;
    return (addr[7:0] & (b - 8'd1)) == 8'd0;
  endfunction

  // Move the unit's bytes into every lane so the enables pick the target lane.
  function automatic logic [31:0] lane_move(input logic [31:0] rdata,
                                            input logic [1:0] src_lo,
                                            input logic [2:0] code);
    logic [31:0] s;
    s = rdata >> {src_lo, 3'b000};
    case (code)
      3'd1: return {4{s[7:0]}};
      3'd2: return {2{s[15:0]}};
      default: return rdata;
    endcase
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] dst_lo, input logic [2:0] code);
    case (code)
      3'd1: return 4'b0001 << dst_lo;
      3'd2: return 4'b0011 << dst_lo;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [COUNT_W-1:0] live_cnt,
  input  logic [31:0]        live_src,
  input  logic [31:0]        live_dst,
  input  logic [31:0]        live_cmd,
  input  logic               ev_done,
  input  logic               ev_tie,
  input  logic               ev_aerr,
  input  logic               ev_halt,
  input  logic               eng_accept,
  output logic               start_req,
  output logic               stop,
  output logic [31:0]        base,
  output logic               stat_done,
  output logic               stat_aerr,
  output logic               irq
);
  localparam logic [REG_AW-1:0] OFS_STAT = REG_AW'(5'h00);
  localparam logic [REG_AW-1:0] OFS_BASE = REG_AW'(5'h04);
  localparam logic [REG_AW-1:0] OFS_BELL = REG_AW'(5'h08);
  localparam logic [REG_AW-1:0] OFS_CNT  = REG_AW'(5'h0C);
  localparam logic [REG_AW-1:0] OFS_SRC  = REG_AW'(5'h10);
  localparam logic [REG_AW-1:0] OFS_DST  = REG_AW'(5'h14);
  localparam logic [REG_AW-1:0] OFS_CMD  = REG_AW'(5'h18);

  logic run_en, fmt8, halted, tie_seen, pend;
  logic wr_stat, wr_bell;

  assign wr_stat   = reg_wr && (reg_addr == OFS_STAT);
  assign wr_bell   = reg_wr && (reg_addr == OFS_BELL) && reg_wdata[0];
  assign stop      = wr_stat && !reg_wdata[0];
  assign start_req = pend && run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      fmt8      <= 1'b0;
      halted    <= 1'b0;
      stat_done <= 1'b0;
      stat_aerr <= 1'b0;
      tie_seen  <= 1'b0;
      pend      <= 1'b0;
      base      <= '0;
    end else begin
      if (wr_stat) begin
        run_en    <= reg_wdata[0];
        fmt8      <= reg_wdata[30];
        halted    <= halted & reg_wdata[2] | ev_halt;
        stat_done <= stat_done & reg_wdata[3] | ev_done;
        tie_seen  <= tie_seen & reg_wdata[3] | (ev_done & ev_tie);
        stat_aerr <= stat_aerr & reg_wdata[4] | ev_aerr;
      end else begin
        halted    <= halted | ev_halt;
        stat_done <= stat_done | ev_done;
        tie_seen  <= tie_seen | (ev_done & ev_tie);
        stat_aerr <= stat_aerr | ev_aerr;
      end
      if (reg_wr && reg_addr == OFS_BASE) base <= reg_wdata;
      if (stop || eng_accept) pend <= 1'b0;
      else if (wr_bell)       pend <= 1'b1;
    end
  end

  assign irq = (stat_done & tie_seen) | stat_aerr | halted;

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {1'b0, fmt8, 25'b0, stat_aerr, stat_done, halted, 1'b0, run_en};
      OFS_BASE: reg_rdata = base;
      OFS_CNT:  reg_rdata = {{(32-COUNT_W){1'b0}}, live_cnt};
      OFS_SRC:  reg_rdata = live_src;
      OFS_DST:  reg_rdata = live_dst;
      OFS_CMD:  reg_rdata = live_cmd;
      default:  reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int COUNT_W     = 24,
  parameter int OFF_W       = 8,
  parameter int OFF_SHIFT   = 4,
  parameter int FETCH_WORDS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic [31:0]        base,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [3:0]         mem_be,
  output logic [31:0]        mem_wdata,
  output logic               accept,
  output logic               busy,
  output logic [COUNT_W-1:0] live_cnt,
  output logic [31:0]        live_src,
  output logic [31:0]        live_dst,
  output logic [31:0]        live_cmd,
  output logic [31:0]        next_addr,
  output logic               ev_done,
  output logic               ev_tie,
  output logic               ev_aerr,
  output logic               ev_halt,
  output logic               unit_done,
  output logic               link_step
);
  localparam int WIDX_W = $clog2(FETCH_WORDS);
  localparam logic [WIDX_W-1:0] W_CMD = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_SRC = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_DST = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_CNT = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] W_REQ = WIDX_W'(4);
  localparam logic [WIDX_W-1:0] W_LAST = WIDX_W'(FETCH_WORDS - 1);

  eng_state_t        st;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       desc_addr, cmd, src_cur, dst_cur, rtype, hold;
  logic [COUNT_W-1:0] cnt;
  logic [OFF_W-1:0]  noff;
  logic [4:0]        beat;

  logic [2:0]  tsz;
  logic [7:0]  ubytes;
  logic        bad, last_beat, link;
  logic [31:0] src_beat, dst_beat, src_step, dst_step;

  assign tsz       = cmd_size(cmd);
  assign ubytes    = unit_bytes(tsz);
  assign link      = cmd[CMD_LINK_BIT];
  assign bad       = !addr_aligned(src_cur, tsz) || !addr_aligned(dst_cur, tsz);
  assign last_beat = (beat == beats_m1(tsz));
  assign src_step  = cmd[CMD_SINC_BIT] ? {24'b0, ubytes} : 32'b0;
  assign dst_step  = cmd[CMD_DINC_BIT] ? {24'b0, ubytes} : 32'b0;
  assign src_beat  = src_cur + (cmd[CMD_SINC_BIT] ? {25'b0, beat, 2'b00} : 32'b0);
  assign dst_beat  = dst_cur + (cmd[CMD_DINC_BIT] ? {25'b0, beat, 2'b00} : 32'b0);
  assign next_addr = base + ({{(32-OFF_W){1'b0}}, noff} << OFF_SHIFT);

  // Named internal events (gated by an abort in the same cycle).
  assign accept    = (st == ENG_IDLE) && start && !abort;
  assign ev_aerr   = (st == ENG_CHECK) && bad && !abort;
  assign ev_halt   = (st == ENG_CHECK) && !bad && (rtype != REQ_AUTO) && !abort;
  assign ev_done   = (st == ENG_END) && !link && !abort;
  assign ev_tie    = cmd[CMD_TIE_BIT];
  assign link_step = (st == ENG_END) && link && !abort;
  assign unit_done = (st == ENG_WRITE) && mem_ack && last_beat && !abort;
  assign busy      = (st != ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ENG_IDLE;
      widx      <= '0;
      desc_addr <= '0;
      cmd       <= '0;
      src_cur   <= '0;
      dst_cur   <= '0;
      rtype     <= '0;
      hold      <= '0;
      cnt       <= '0;
      noff      <= '0;
      beat      <= '0;
    end else if (abort) begin
      st <= ENG_IDLE;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          desc_addr <= base;
          widx      <= '0;
          st        <= ENG_FETCH;
        end
        ENG_FETCH: if (mem_ack) begin
          case (widx)
            W_CMD: cmd     <= mem_rdata;
            W_SRC: src_cur <= mem_rdata;
            W_DST: dst_cur <= mem_rdata;
            W_CNT: begin
              cnt  <= mem_rdata[COUNT_W-1:0];
              noff <= mem_rdata[31 -: OFF_W];
            end
            W_REQ: rtype   <= mem_rdata;
            default: ;
          endcase
          if (widx == W_LAST) st <= ENG_CHECK;
          else widx <= widx + WIDX_W'(1);
        end
        ENG_CHECK: begin
          beat <= '0;
          if (bad || rtype != REQ_AUTO) st <= ENG_IDLE;
          else if (cnt == '0)           st <= ENG_END;
          else                          st <= ENG_READ;
        end
        ENG_READ: if (mem_ack) begin
          hold <= mem_rdata;
          st   <= ENG_WRITE;
        end
        ENG_WRITE: if (mem_ack) begin
          if (last_beat) begin
            cnt     <= cnt - COUNT_W'(1);
            src_cur <= src_cur + src_step;
            dst_cur <= dst_cur + dst_step;
            beat    <= '0;
            st      <= (cnt == COUNT_W'(1)) ? ENG_END : ENG_READ;
          end else begin
            beat <= beat + 5'd1;
            st   <= ENG_READ;
          end
        end
        ENG_END: begin
          if (link) begin
            desc_addr <= next_addr;
            widx      <= '0;
            st        <= ENG_FETCH;
          end else begin
            st <= ENG_IDLE;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'h0;
    mem_be    = 4'hF;
    mem_wdata = 32'h0;
    case (st)
      ENG_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + {{(30-WIDX_W){1'b0}}, widx, 2'b00};
      end
      ENG_READ: begin
        mem_req  = 1'b1;
        mem_addr = {src_beat[31:2], 2'b00};
      end
      ENG_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {dst_beat[31:2], 2'b00};
        mem_be    = lane_be(dst_cur[1:0], tsz);
        mem_wdata = lane_move(hold, src_cur[1:0], tsz);
      end
      default: ;
    endcase
  end

  assign live_cnt = cnt;
  assign live_src = src_cur;
  assign live_dst = dst_cur;
  assign live_cmd = cmd;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int REG_AW      = 5,
  parameter int COUNT_W     = 24,
  parameter int OFF_W       = 8,
  parameter int OFF_SHIFT   = 4,
  parameter int FETCH_WORDS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);
  logic [COUNT_W-1:0] live_cnt;
  logic [31:0] live_src, live_dst, live_cmd, base, next_addr;
  logic ev_done, ev_tie, ev_aerr, ev_halt, accept, busy, unit_done, link_step;
  logic start_req, stop, stat_done, stat_aerr;

  dma_chan_regs #(.REG_AW(REG_AW), .COUNT_W(COUNT_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .live_cnt, .live_src, .live_dst, .live_cmd,
    .ev_done, .ev_tie, .ev_aerr, .ev_halt, .eng_accept(accept),
    .start_req, .stop, .base, .stat_done, .stat_aerr, .irq
  );

  dma_chan_engine #(
    .COUNT_W(COUNT_W), .OFF_W(OFF_W), .OFF_SHIFT(OFF_SHIFT), .FETCH_WORDS(FETCH_WORDS)
  ) u_eng (
    .clk, .rst_n, .start(start_req), .abort(stop), .base,
    .mem_ack, .mem_rdata, .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata,
    .accept, .busy, .live_cnt, .live_src, .live_dst, .live_cmd, .next_addr,
    .ev_done, .ev_tie, .ev_aerr, .ev_halt, .unit_done, .link_step
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int COUNT_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               mem_req,
  input logic               mem_we,
  input logic [31:0]        mem_addr,
  input logic [31:0]        base,
  input logic [31:0]        next_addr,
  input logic               busy,
  input logic               accept,
  input logic               stop,
  input logic               unit_done,
  input logic               link_step,
  input logic               ev_done,
  input logic               ev_aerr,
  input logic               ev_halt,
  input logic               stat_done,
  input logic               stat_aerr,
  input logic [COUNT_W-1:0] live_cnt
);
  a_r2_fetch_from_base: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req && !mem_we && mem_addr == $past(base));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> live_cnt == $past(live_cnt) - COUNT_W'(1));

  a_r6_link_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    link_step |=> mem_req && !mem_we && mem_addr == $past(next_addr));

  a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> stat_done);

  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aerr |=> stat_aerr && !busy && irq);

  a_r9_halt_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> irq && !mem_req);

  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy && !mem_req);
endmodule

bind dma_chan dma_chan_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk, .rst_n, .irq, .mem_req, .mem_we, .mem_addr, .base, .next_addr, .busy,
  .accept, .stop, .unit_done, .link_step, .ev_done, .ev_aerr, .ev_halt,
  .stat_done, .stat_aerr, .live_cnt
);

// File: tb/tb_dma_chan.sv
`timescale 1ns/1ps
module tb_dma_chan;
  localparam logic [4:0] A_STAT = 5'h00, A_BASE = 5'h04, A_BELL = 5'h08, A_CNT = 5'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  logic [31:0] mem [0:1023];
  logic ld_en = 1'b0;
  logic [31:0] ld_addr = '0, ld_data = '0;
  int wr_count = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan dut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ack, .mem_rdata, .irq
  );

  // Zero-wait memory model.
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr[11:2]] <= ld_data;
    else if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input bit link, input bit tie, input logic [2:0] tsz,
                                         input bit sinc, input bit dinc);
    return {8'b0, sinc, dinc, 11'b0, tsz, 6'b0, tie, link};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] cmd, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] cntw, input logic [31:0] rt);
    put_word(a, cmd); put_word(a + 4, src); put_word(a + 8, dst);
    put_word(a + 12, cntw); put_word(a + 16, rt);
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic start_chan(input logic [31:0] b);
    reg_write(A_STAT, 32'h0);
    reg_write(A_BASE, b);
    reg_write(A_BELL, 32'h1);
    reg_write(A_STAT, 32'h4000_0001);
  endtask

  task automatic wait_flags(output logic [31:0] s);
    s = 0;
    for (int i = 0; i < 3000; i++) begin
      reg_read(A_STAT, s);
      if ((s & 32'h1C) != 0) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(A_STAT, v); check("R1", "status", v, 32'h0);
    reg_read(A_CNT, v);  check("R1", "count", v, 32'h0);
    check("R1", "irq", {31'b0, irq}, 32'h0);
    check("R1", "mem_req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_word_copy;
    logic [31:0] s;
    for (int i = 0; i < 4; i++) put_word(32'h100 + 4*i, 32'hA000_0000 + i);
    put_desc(32'h000, mk_cmd(0, 1, 3'd0, 1, 1), 32'h100, 32'h140, 32'd4, 32'd8);
    start_chan(32'h000);
    wait_flags(s);
    check("R7", "status after chain end", s, 32'h4000_0009);
    check("R7", "irq with interrupt enable", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 4; i++) check("R2", "4-byte copy", mem[(32'h140 >> 2) + i], 32'hA000_0000 + i);
    reg_read(A_CNT, s); check("R5", "count at end", s, 32'h0);
  endtask

  task automatic t_byte_copy;
    logic [31:0] s;
    put_word(32'h180, 32'h4433_2211); put_word(32'h184, 32'h8877_6655);
    put_word(32'h1C0, 32'hAAAA_AAAA); put_word(32'h1C4, 32'hBBBB_BBBB);
    put_desc(32'h020, mk_cmd(0, 1, 3'd1, 1, 1), 32'h181, 32'h1C2, 32'd3, 32'd8);
    start_chan(32'h020);
    wait_flags(s);
    check("R3", "byte lanes word0", mem[32'h1C0 >> 2], 32'h3322_AAAA);
    check("R3", "byte lanes word1", mem[32'h1C4 >> 2], 32'hBBBB_BB44);
  endtask

  task automatic t_fixed_src;
    logic [31:0] s;
    for (int i = 0; i < 4; i++) put_word(32'h200 + 4*i, 32'h5500_0000 + i);
    for (int i = 0; i < 8; i++) put_word(32'h240 + 4*i, 32'h0);
    put_desc(32'h040, mk_cmd(0, 1, 3'd3, 0, 1), 32'h200, 32'h240, 32'd2, 32'd8);
    start_chan(32'h040);
    wait_flags(s);
    for (int i = 0; i < 8; i++) check("R4", "fixed source word", mem[(32'h240 >> 2) + i], 32'h5500_0000);
    reg_read(5'h10, s); check("R4", "source not advanced", s, 32'h200);
    reg_read(5'h14, s); check("R4", "target advanced", s, 32'h260);
  endtask

  task automatic t_chain;
    logic [31:0] s;
    put_word(32'h480, 32'h1111_0001); put_word(32'h484, 32'h2222_0002);
    put_word(32'h4A0, 32'h0); put_word(32'h4A4, 32'h0);
    put_desc(32'h400, mk_cmd(1, 1, 3'd0, 1, 1), 32'h480, 32'h4A0, {8'd2, 24'd1}, 32'd8);
    put_desc(32'h420, mk_cmd(0, 0, 3'd0, 1, 1), 32'h484, 32'h4A4, 32'd1, 32'd8);
    start_chan(32'h400);
    wait_flags(s);
    check("R6", "first link copy", mem[32'h4A0 >> 2], 32'h1111_0001);
    check("R6", "second copy at base+32", mem[32'h4A4 >> 2], 32'h2222_0002);
    check("R7", "terminated flag", s, 32'h4000_0009);
    check("R6", "no irq from linked TIE, last TIE clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_errors;
    logic [31:0] s;
    put_word(32'h540, 32'hDEAD_0000);
    put_desc(32'h0A0, mk_cmd(0, 1, 3'd0, 1, 1), 32'h502, 32'h540, 32'd1, 32'd8);
    start_chan(32'h0A0);
    wait_flags(s);
    check("R8", "misaligned status", s, 32'h4000_0011);
    check("R8", "misaligned irq", {31'b0, irq}, 32'h1);
    check("R8", "no write on error", mem[32'h540 >> 2], 32'hDEAD_0000);
    reg_write(A_STAT, 32'h0);
    reg_read(A_STAT, s); check("R10", "status cleared by write 0", s, 32'h0);
    check("R10", "irq cleared", {31'b0, irq}, 32'h0);

    put_word(32'h580, 32'hDEAD_0001);
    put_desc(32'h0C0, mk_cmd(0, 1, 3'd7, 1, 1), 32'h560, 32'h580, 32'd1, 32'd8);
    start_chan(32'h0C0);
    wait_flags(s);
    check("R8", "size code 7 status", s, 32'h4000_0011);
    check("R8", "size code 7 no write", mem[32'h580 >> 2], 32'hDEAD_0001);

    put_word(32'h5C0, 32'h1234_5678);
    put_desc(32'h0E0, mk_cmd(0, 0, 3'd0, 1, 1), 32'h5A0, 32'h5C0, 32'd1, 32'd3);
    start_chan(32'h0E0);
    wait_flags(s);
    check("R9", "halt status", s, 32'h4000_0005);
    check("R9", "halt irq", {31'b0, irq}, 32'h1);
    check("R9", "no write on halt", mem[32'h5C0 >> 2], 32'h1234_5678);
  endtask

  task automatic t_live_count;
    logic [31:0] s;
    put_word(32'h78C, 32'hC0DE_0063);
    put_desc(32'h100 - 32'h60, mk_cmd(0, 1, 3'd0, 1, 1), 32'h600, 32'h800, 32'd100, 32'd8);
    start_chan(32'h0A0);
    repeat (50) @(negedge clk);
    reg_read(A_CNT, s);
    n_chk++;
    if (s < 60 || s > 95) begin
      n_bad++;
      $display("FAIL R5 live count mid-transfer: actual=%0d expected=60..95", s);
    end
    wait_flags(s);
    reg_read(A_CNT, s); check("R5", "count drained", s, 32'h0);
    check("R5", "last unit copied", mem[32'h98C >> 2], 32'hC0DE_0063);
  endtask

  task automatic t_cyclic;
    logic [31:0] s;
    int w0;
    bit idle_ok;
    put_word(32'h340, 32'h7777_0000); put_word(32'h344, 32'h7777_0001);
    put_desc(32'h300, mk_cmd(1, 1, 3'd0, 1, 1), 32'h340, 32'h380, 32'd2, 32'd8);
    w0 = wr_count;
    start_chan(32'h300);
    repeat (200) @(negedge clk);
    n_chk++;
    if (wr_count - w0 <= 4) begin
      n_bad++;
      $display("FAIL R10 cyclic writes: actual=%0d expected>4", wr_count - w0);
    end
    reg_read(A_STAT, s); check("R10", "no terminated flag while looping", s, 32'h4000_0001);
    check("R10", "cyclic data", mem[32'h384 >> 2], 32'h7777_0001);
    reg_write(A_STAT, 32'h0);
    w0 = wr_count;
    idle_ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) idle_ok = 0;
    end
    check("R10", "idle after stop", {31'b0, idle_ok}, 32'h1);
    check("R10", "no writes after stop", wr_count - w0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_word_copy;
    t_byte_copy;
    t_fixed_src;
    t_chain;
    t_errors;
    t_live_count;
    t_cyclic;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule